// File: doc/BRIEF.md
# Secondary Interrupt Aggregator with Direct Routing

This block gathers thirty-two level-sensitive interrupt requests from peripherals and offers them to a primary interrupt controller in two ways. Every line that is both asserted and enabled contributes to a single combined request, which leaves on output line 31. In addition, the ten lines 21 through 30 can each be forwarded on their own, one-for-one, to the output with the same index, under a separate routing-enable register.

Software controls the block through a small 32-bit register bus with one access per cycle over a 4 KB window. The enable and routing registers are changed with set-style and clear-style writes, so two drivers can update separate bits without a read-modify-write. A pair of registers sets or clears only enable bit 0, and a read of the first of the pair returns the current level of input 0. The inputs are taken as synchronous to the block clock, and all outputs are registered.

Top module: `sic_top`

## Requirements
- R1: After reset the level, enable and routing registers read zero and every output line is low.
- R2: Word index 1 (address bits [11:2]) reads the input levels captured at the last clock edge; a bit falls as soon as its input is low at an edge, with no latching.
- R3: Word index 0 reads the bitwise AND of the captured levels and the enable mask.
- R4: A write to index 2 ORs the written value into the enable mask and a read of index 2 returns the mask; a write to index 3 clears each enable bit written as 1.
- R5: A read of index 4 returns captured input 0 in bit 0 and zeros above it; a nonzero write to index 4 sets enable bit 0, a nonzero write to index 5 clears it, and a zero write to either leaves the mask unchanged.
- R6: A read of index 8 returns the routing mask; a write to index 8 ORs in only bits 21 to 30 of the written value; a write to index 9 clears each routing bit written as 1.
- R7: Output line 31 is high exactly when some captured level is high with its enable bit set.
- R8: For each line i from 21 to 30, output i equals captured input i when routing bit i is set and is low otherwise.
- R9: Output lines 0 to 20 are always low.
- R10: Reads of any other index return zero; writes to indexes 0, 1 and any other index change no register and no output.
- R11: An input change or a register write presented before a clock edge shows on the outputs right after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Register access strobe, one access per cycle |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address inside the window; bits [11:2] give the word index |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the cycle of the read access |
| irqIn | input | 32 | Level-sensitive interrupt requests |
| irqOut | output | 32 | Routed lines 21 to 30 and the combined request on line 31 |

## Verification
The output function is driven with a table of level and mask patterns: a lone enabled line, routed lines with the combined request disabled, all-ones inputs with an all-ones routing write, disjoint levels and enables, line 31 as its own input, and a mix of routed and combined lines. Each pattern separates the combined OR from the per-line routing, shows whether a routing write leaks outside the band, and shows whether low lines stay quiet. Directed cases then probe the bit-0 set and clear registers with zero and nonzero data, unmapped and read-only indexes, and the exact edge at which outputs respond to inputs and writes.

// File: rtl/sic_pkg.sv
package sic_pkg;

  // Source selected for the read data path
  typedef enum logic [2:0] {
    RD_NONE,
    RD_STATUS,
    RD_LEVEL,
    RD_ENABLE,
    RD_BIT0,
    RD_ROUTE
  } rdSel_e;

  // Update strobes from register decode to state
  typedef struct packed {
    logic enSet;
    logic enClr;
    logic bit0Set;
    logic bit0Clr;
    logic routeSet;
    logic routeClr;
  } strobe_t;

endpackage

// File: rtl/sic_ctrl.sv
module sic_ctrl
  import sic_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output strobe_t           stb,
  output rdSel_e            rdSel
);

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] IDX_STATUS   = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_LEVEL    = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_ENSET    = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_ENCLR    = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_B0SET    = IDX_W'(4);
  localparam logic [IDX_W-1:0] IDX_B0CLR    = IDX_W'(5);
  localparam logic [IDX_W-1:0] IDX_ROUTESET = IDX_W'(8);
  localparam logic [IDX_W-1:0] IDX_ROUTECLR = IDX_W'(9);

  logic [IDX_W-1:0] wordIdx;
  logic             doWrite;
  logic             doRead;
  logic             dataNz;

  assign wordIdx = paddr[ADDR_W-1:2];
  assign doWrite = psel && pwrite;
  assign doRead  = psel && !pwrite;
  assign dataNz  = |pwdata;

  always_comb begin
    stb = '0;
    if (doWrite) begin
      unique case (wordIdx)
        IDX_ENSET:    stb.enSet    = 1'b1;
        IDX_ENCLR:    stb.enClr    = 1'b1;
        IDX_B0SET:    stb.bit0Set  = dataNz;
        IDX_B0CLR:    stb.bit0Clr  = dataNz;
        IDX_ROUTESET: stb.routeSet = 1'b1;
        IDX_ROUTECLR: stb.routeClr = 1'b1;
        default:      stb = '0;
      endcase
    end
  end

  always_comb begin
    rdSel = RD_NONE;
    if (doRead) begin
      unique case (wordIdx)
        IDX_STATUS:   rdSel = RD_STATUS;
        IDX_LEVEL:    rdSel = RD_LEVEL;
        IDX_ENSET:    rdSel = RD_ENABLE;
        IDX_B0SET:    rdSel = RD_BIT0;
        IDX_ROUTESET: rdSel = RD_ROUTE;
        default:      rdSel = RD_NONE;
      endcase
    end
  end

  // R10
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  // R10
  unmapped_write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doWrite && (wordIdx == IDX_STATUS || wordIdx == IDX_LEVEL || wordIdx > IDX_ROUTECLR))
      |-> (stb == '0));

  // R10
  read_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    doRead |-> (stb == '0));

endmodule

// File: rtl/sic_datapath.sv
module sic_datapath
  import sic_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ROUTE_LO  = 21,
  parameter int ROUTE_HI  = 30,
  parameter int AGG_LINE  = 31
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  strobe_t              stb,
  input  logic [NUM_LINES-1:0] wdata,
  input  rdSel_e               rdSel,
  output logic [NUM_LINES-1:0] rdata,
  output logic [NUM_LINES-1:0] irqOut
);

  function automatic logic [NUM_LINES-1:0] bandMask();
    logic [NUM_LINES-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (i >= ROUTE_LO && i <= ROUTE_HI) m[i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [NUM_LINES-1:0] ROUTE_MASK = bandMask();
  localparam logic [NUM_LINES-1:0] AGG_BIT    = NUM_LINES'(1) << AGG_LINE;

  logic [NUM_LINES-1:0] levelQ, enableQ, routeQ;
  logic [NUM_LINES-1:0] levelNext, enableNext, routeNext;
  logic [NUM_LINES-1:0] outNext;
  logic                 aggNext;

  assign levelNext = irqIn;

  always_comb begin
    enableNext = enableQ;
    if (stb.enSet)   enableNext = enableQ | wdata;
    if (stb.enClr)   enableNext = enableQ & ~wdata;
    if (stb.bit0Set) enableNext[0] = 1'b1;
    if (stb.bit0Clr) enableNext[0] = 1'b0;
  end

  always_comb begin
    routeNext = routeQ;
    if (stb.routeSet) routeNext = routeQ | (wdata & ROUTE_MASK);
    if (stb.routeClr) routeNext = routeQ & ~wdata;
  end

  assign aggNext = |(levelNext & enableNext);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    if (i == AGG_LINE) begin : g_agg
      assign outNext[i] = aggNext;
    end else if (i >= ROUTE_LO && i <= ROUTE_HI) begin : g_route
      assign outNext[i] = levelNext[i] & routeNext[i];
    end else begin : g_tie
      assign outNext[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ  <= '0;
      enableQ <= '0;
      routeQ  <= '0;
      irqOut  <= '0;
    end else begin
      levelQ  <= levelNext;
      enableQ <= enableNext;
      routeQ  <= routeNext;
      irqOut  <= outNext;
    end
  end

  always_comb begin
    unique case (rdSel)
      RD_STATUS: rdata = levelQ & enableQ;
      RD_LEVEL:  rdata = levelQ;
      RD_ENABLE: rdata = enableQ;
      RD_BIT0:   rdata = {{(NUM_LINES-1){1'b0}}, levelQ[0]};
      RD_ROUTE:  rdata = routeQ;
      default:   rdata = '0;
    endcase
  end

  // R7
  agg_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut[AGG_LINE] == (|(levelQ & enableQ)));

  // R9
  quiet_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut & ~(ROUTE_MASK | AGG_BIT)) == '0);

  // R6
  route_band_chk: assert property (@(posedge clk) disable iff (!rstN)
    (routeQ & ~ROUTE_MASK) == '0);

  // R5
  bit0_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.bit0Set |=> enableQ[0]);

  // R5
  bit0_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.bit0Clr |=> !enableQ[0]);

  // R4
  en_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.enClr |=> ((enableQ & $past(wdata)) == '0));

  for (genvar j = ROUTE_LO; j <= ROUTE_HI; j++) begin : g_route_chk
    // R8
    route_line_chk: assert property (@(posedge clk) disable iff (!rstN)
      irqOut[j] == (levelQ[j] & routeQ[j]));
  end

endmodule

// File: rtl/sic_top.sv
module sic_top
  import sic_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_LINES = 32,
  parameter int ROUTE_LO  = 21,
  parameter int ROUTE_HI  = 30,
  parameter int AGG_LINE  = 31
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 psel,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [NUM_LINES-1:0] pwdata,
  output logic [NUM_LINES-1:0] prdata,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic [NUM_LINES-1:0] irqOut
);

  strobe_t stb;
  rdSel_e  rdSel;

  sic_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (NUM_LINES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .psel   (psel),
    .pwrite (pwrite),
    .paddr  (paddr),
    .pwdata (pwdata),
    .stb    (stb),
    .rdSel  (rdSel)
  );

  sic_datapath #(
    .NUM_LINES (NUM_LINES),
    .ROUTE_LO  (ROUTE_LO),
    .ROUTE_HI  (ROUTE_HI),
    .AGG_LINE  (AGG_LINE)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .irqIn  (irqIn),
    .stb    (stb),
    .wdata  (pwdata),
    .rdSel  (rdSel),
    .rdata  (prdata),
    .irqOut (irqOut)
  );

endmodule

// File: tb/tb_sic_top.sv
`timescale 1ns/1ps
module tb_sic_top;

  localparam logic [31:0] BAND = 32'h7FE0_0000;

  typedef struct packed {
    logic [31:0] irq;
    logic [31:0] en;
    logic [31:0] route;
    logic [31:0] expOut;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 32'h8000_0000},
    '{32'h0060_0000, 32'h0000_0000, 32'h0020_0000, 32'h0020_0000},
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h7FE0_0000},
    '{32'h0000_FFFF, 32'hFFFF_0000, 32'h7FE0_0000, 32'h0000_0000},
    '{32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 32'h8000_0000},
    '{32'h4000_0010, 32'h0000_0010, 32'h4000_0000, 32'hC000_0000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0;
  logic        pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [31:0] irqIn = '0;
  logic [31:0] irqOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  sic_top dut (
    .clk(clk), .rstN(rstN), .psel(psel), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata), .irqIn(irqIn), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the following negedge
  task automatic busWrite(input int idx, input logic [31:0] data);
    psel = 1'b1; pwrite = 1'b1; paddr = 12'(idx << 2); pwdata = data;
    @(posedge clk);
    @(negedge clk);
    psel = 1'b0; pwrite = 1'b0; pwdata = '0;
  endtask

  task automatic busRead(input int idx, output logic [31:0] data);
    psel = 1'b1; pwrite = 1'b0; paddr = 12'(idx << 2);
    #1;
    data = prdata;
    psel = 1'b0;
  endtask

  task automatic clearAll();
    busWrite(3, 32'hFFFF_FFFF);
    busWrite(9, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out during reset", irqOut, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 out after reset", irqOut, 32'h0);
    busRead(1, rd); check("R1 level", rd, 32'h0);
    busRead(2, rd); check("R1 enable", rd, 32'h0);
    busRead(8, rd); check("R1 route", rd, 32'h0);

    // Table: R2 R3 R6 R7 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      clearAll();
      busWrite(2, VECS[v].en);
      busWrite(8, VECS[v].route);
      irqIn = VECS[v].irq;
      @(posedge clk);
      @(negedge clk);
      check("R7 R8 R9 outputs", irqOut, VECS[v].expOut);
      busRead(1, rd); check("R2 level", rd, VECS[v].irq);
      busRead(0, rd); check("R3 status", rd, VECS[v].irq & VECS[v].en);
      busRead(8, rd); check("R6 route", rd, VECS[v].route & BAND);
      busRead(2, rd); check("R4 enable", rd, VECS[v].en);
    end

    // R2 no latching: drop all inputs
    irqIn = '0;
    @(posedge clk); @(negedge clk);
    busRead(1, rd); check("R2 level falls", rd, 32'h0);
    check("R8 routed lines fall", irqOut, 32'h0);

    // R4 set accumulates, clear by ones
    clearAll();
    busWrite(2, 32'h0000_00F0);
    busWrite(2, 32'h0000_0F00);
    busRead(2, rd); check("R4 OR accumulate", rd, 32'h0000_0FF0);
    busWrite(3, 32'h0000_0330);
    busRead(2, rd); check("R4 clear ones", rd, 32'h0000_0CC0);

    // R5 bit0 set/clear and level read
    busWrite(4, 32'h0);
    busRead(2, rd); check("R5 zero set no effect", rd, 32'h0000_0CC0);
    busWrite(4, 32'h0001_0000);
    busRead(2, rd); check("R5 nonzero set", rd, 32'h0000_0CC1);
    busWrite(5, 32'h0);
    busRead(2, rd); check("R5 zero clear no effect", rd, 32'h0000_0CC1);
    busWrite(5, 32'h8000_0000);
    busRead(2, rd); check("R5 nonzero clear", rd, 32'h0000_0CC0);
    irqIn = 32'h0000_0003;
    @(posedge clk); @(negedge clk);
    busRead(4, rd); check("R5 level bit0 read", rd, 32'h0000_0001);

    // R6 route clear
    busWrite(8, 32'hFFFF_FFFF);
    busWrite(9, 32'h0F00_0000);
    busRead(8, rd); check("R6 route clear", rd, 32'h70E0_0000);

    // R10 unmapped and read-only
    busRead(6, rd);     check("R10 unmapped read 6", rd, 32'h0);
    busRead(10'h3FF, rd); check("R10 unmapped read top", rd, 32'h0);
    busRead(3, rd);     check("R10 read of clear index", rd, 32'h0);
    busWrite(7, 32'hFFFF_FFFF);
    busWrite(0, 32'hFFFF_FFFF);
    busWrite(1, 32'hFFFF_FFFF);
    busWrite(12, 32'hFFFF_FFFF);
    busRead(2, rd); check("R10 enable untouched", rd, 32'h0000_0CC0);
    busRead(8, rd); check("R10 route untouched", rd, 32'h70E0_0000);
    check("R10 outputs untouched", irqOut, 32'h0);

    // R11 timing of input change
    clearAll();
    busWrite(2, 32'h0000_0001);
    irqIn = '0;
    @(posedge clk); @(negedge clk);
    irqIn = 32'h0000_0001;
    #1;
    check("R11 before edge input", irqOut, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R11 after edge input", irqOut, 32'h8000_0000);

    // R11 timing of write
    busWrite(3, 32'h0000_0001);
    check("R11 clear takes effect", irqOut, 32'h0);
    psel = 1'b1; pwrite = 1'b1; paddr = 12'(2 << 2); pwdata = 32'h1;
    #1;
    check("R11 before edge write", irqOut, 32'h0);
    @(posedge clk); @(negedge clk);
    psel = 1'b0; pwrite = 1'b0; pwdata = '0;
    check("R11 after edge write", irqOut, 32'h8000_0000);

    // R1 reset mid-run
    busWrite(8, 32'hFFFF_FFFF);
    irqIn = '0;
    rstN = 1'b0;
    @(posedge clk); @(negedge clk);
    rstN = 1'b1;
    busRead(2, rd); check("R1 enable after reset", rd, 32'h0);
    busRead(8, rd); check("R1 route after reset", rd, 32'h0);
    check("R1 out after re-reset", irqOut, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule